// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block turns one PWM bit into two complementary enables for the two switches of a half-bridge. The true enable follows the PWM level and the complement enable follows its inverse. Each time the sampled PWM level changes, in either direction, both enables are forced low for a programmable number of clock cycles. During that window the switch being turned off can discharge before the other one is turned on.

The PWM bit is registered on every clock edge. A blanking stage decides whether the current sample has matched every earlier sample for at least the programmed number of cycles. Both enables come from one register stage that is driven by the same sample and the same blanking decision, so neither path leads the other. Two blanking variants can be chosen by parameter: a saturating run-length counter (the default) or a history shift register with a selectable tap window. Both variants give the same cycle behaviour.

Top module: `dead_time_gen`

## Requirements
- R1: When `pwm_in` is first sampled high at clock edge k and stays high, `en_true` goes high at edge k + D, where D is the effective dead time. Both enables are low at edges k through k + D − 1.
- R2: When `pwm_in` is first sampled low at clock edge k and stays low, `en_comp` goes high at edge k + D. Both enables are low at edges k through k + D − 1.
- R3: The enable that matches the old level drops at the same clock edge that first samples the new `pwm_in` level.
- R4: `en_true` and `en_comp` are never high in the same cycle.
- R5: If `pwm_in` changes again before the dead time has run out, both enables stay low. The enable for the final level rises only after that level has been sampled on D + 1 consecutive edges.
- R6: The effective dead time D equals `dead_cycles`, except that a value of 0 is treated as 1.
- R7: `rst` is synchronous and active high. While `rst` is sampled high, both enables are low at the next edge and the blanking history is loaded with the current `pwm_in`. At the first edge after release, the enable matching an unchanged `pwm_in` goes high with no blanking.
- R8: The largest dead time, 2^DT_W − 1 cycles (255 with default parameters), is honoured exactly. An enable then stays high for as long as its input level is held, with no limit on the run length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM level to be split into complementary enables |
| dead_cycles | input | DT_W | Dead time in clock cycles (0 is treated as 1) |
| en_true | output | 1 | Enable that follows `pwm_in` after blanking |
| en_comp | output | 1 | Enable that follows the inverse of `pwm_in` after blanking |

## Verification
The hardest case to reach is a retoggle inside the blanking window. In that case the run of equal samples restarts while the window is still open, and the enables must stay low past the point where the first edge alone would have released them. The vector table creates this case by toggling the input twice within one dead time and by alternating it on every cycle with the smallest dead time. It then counts the exact edge where the final level's enable appears. Directed tests also hold the largest dead time for its full length, to reach counter saturation, and reset the block while one enable is high.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   // Selects how the blanking window is measured.
   typedef enum logic {
      DTG_RUN_COUNT = 1'b0,   // saturating counter of equal samples
      DTG_HIST_TAP  = 1'b1    // history shift register with tap window
   } dtg_impl_e;

   localparam int DTG_MIN_W = 2;
   localparam int DTG_MAX_W = 16;

endpackage

// File: rtl/dtg_run_counter.sv
// Blanking by run length: counts how many earlier samples matched the current one.
module dtg_run_counter #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            samp,
   input  logic [DT_W-1:0] dt_eff,
   output logic            quiet
);
   localparam logic [DT_W-1:0] RUN_MAX = {DT_W{1'b1}};

   logic            prev_q;
   logic [DT_W-1:0] run_q;
   logic [DT_W-1:0] run_nx;

   always_comb begin
      if (samp != prev_q)      run_nx = '0;
      else if (run_q == RUN_MAX) run_nx = run_q;
      else                      run_nx = run_q + 1'b1;
      quiet = (run_nx >= dt_eff);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= samp;
         run_q  <= RUN_MAX;
      end else begin
         prev_q <= samp;
         run_q  <= run_nx;
      end
   end
endmodule

// File: rtl/dtg_hist_tap.sv
// Blanking by history: the current sample must equal the last dt_eff samples.
module dtg_hist_tap #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            samp,
   input  logic [DT_W-1:0] dt_eff,
   output logic            quiet
);
   localparam int DEPTH = (1 << DT_W) - 1;

   logic [DEPTH-1:0] hist_q;

   always_comb begin
      quiet = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
         if ((dt_eff > DT_W'(k)) && (hist_q[k] != samp)) quiet = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) hist_q <= {DEPTH{samp}};
      else     hist_q <= {hist_q[DEPTH-2:0], samp};
   end
endmodule

// File: rtl/dtg_drive_pair.sv
// One register stage for both enables, so the two paths see matched delay.
module dtg_drive_pair (
   input  logic clk,
   input  logic rst,
   input  logic samp,
   input  logic quiet,
   output logic en_true,
   output logic en_comp
);
   always_ff @(posedge clk) begin
      if (rst) begin
         en_true <= 1'b0;
         en_comp <= 1'b0;
      end else begin
         en_true <=  samp & quiet;
         en_comp <= ~samp & quiet;
      end
   end
endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen
   import dtg_pkg::*;
#(
   parameter int        DT_W = 8,
   parameter dtg_impl_e IMPL = DTG_RUN_COUNT
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pwm_in,
   input  logic [DT_W-1:0] dead_cycles,
   output logic            en_true,
   output logic            en_comp
);
   localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

   generate
      if (DT_W < DTG_MIN_W || DT_W > DTG_MAX_W) begin : g_bad_width
         $error("dead_time_gen: DT_W out of supported range");
      end
   endgenerate

   logic [DT_W-1:0] dt_eff;
   logic            quiet;

   // R6: zero dead time is raised to one cycle
   assign dt_eff = (dead_cycles == '0) ? DT_ONE : dead_cycles;

   generate
      if (IMPL == DTG_HIST_TAP) begin : g_hist
         dtg_hist_tap #(.DT_W(DT_W)) u_blank (
            .clk   (clk),
            .rst   (rst),
            .samp  (pwm_in),
            .dt_eff(dt_eff),
            .quiet (quiet)
         );
      end else begin : g_count
         dtg_run_counter #(.DT_W(DT_W)) u_blank (
            .clk   (clk),
            .rst   (rst),
            .samp  (pwm_in),
            .dt_eff(dt_eff),
            .quiet (quiet)
         );
      end
   endgenerate

   dtg_drive_pair u_drive (
      .clk    (clk),
      .rst    (rst),
      .samp   (pwm_in),
      .quiet  (quiet),
      .en_true(en_true),
      .en_comp(en_comp)
   );
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk (
   input logic clk,
   input logic rst,
   input logic pwm_in,
   input logic en_true,
   input logic en_comp
);
   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      !(en_true && en_comp));

   // R1
   true_level_chk: assert property (@(posedge clk) disable iff (rst)
      en_true |-> $past(pwm_in));

   // R2
   comp_level_chk: assert property (@(posedge clk) disable iff (rst)
      en_comp |-> !$past(pwm_in));

   // R3
   edge_blank_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(pwm_in) != $past(pwm_in, 2)) |-> (!en_true && !en_comp));

   // R7
   reset_low_chk: assert property (@(posedge clk)
      rst |=> (!en_true && !en_comp));
endmodule

bind dead_time_gen dtg_chk u_dtg_chk (
   .clk    (clk),
   .rst    (rst),
   .pwm_in (pwm_in),
   .en_true(en_true),
   .en_comp(en_comp)
);

// File: tb/tb_dead_time_gen.sv
module tb_dead_time_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pwm_in = 1'b0;
   logic [7:0] dead_cycles = 8'd3;
   logic       en_true;
   logic       en_comp;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dead_time_gen #(.DT_W(8)) dut (
      .clk        (clk),
      .rst        (rst),
      .pwm_in     (pwm_in),
      .dead_cycles(dead_cycles),
      .en_true    (en_true),
      .en_comp    (en_comp)
   );

   // Row: {pwm, dead_cycles, exp_true, exp_comp, requirement number}
   localparam int NV = 26;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 8'd3, 1'b0, 1'b1, 4'd7},  // R7 no blanking after release
      {1'b0, 8'd3, 1'b0, 1'b1, 4'd2},
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd3},  // R3 comp drops at once
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd1},
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd1},
      {1'b1, 8'd3, 1'b1, 1'b0, 4'd1},  // R1 rises at k+3
      {1'b1, 8'd3, 1'b1, 1'b0, 4'd1},
      {1'b0, 8'd3, 1'b0, 1'b0, 4'd3},  // R3 true drops at once
      {1'b0, 8'd3, 1'b0, 1'b0, 4'd2},
      {1'b0, 8'd3, 1'b0, 1'b0, 4'd2},
      {1'b0, 8'd3, 1'b0, 1'b1, 4'd2},  // R2 rises at k+3
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd5},
      {1'b0, 8'd3, 1'b0, 1'b0, 4'd5},  // R5 retoggle inside window
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd5},
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd5},
      {1'b1, 8'd3, 1'b0, 1'b0, 4'd5},
      {1'b1, 8'd3, 1'b1, 1'b0, 4'd5},
      {1'b0, 8'd0, 1'b0, 1'b0, 4'd6},  // R6 zero acts as one
      {1'b0, 8'd0, 1'b0, 1'b1, 4'd6},
      {1'b1, 8'd0, 1'b0, 1'b0, 4'd6},
      {1'b1, 8'd0, 1'b1, 1'b0, 4'd6},
      {1'b0, 8'd1, 1'b0, 1'b0, 4'd5},
      {1'b1, 8'd1, 1'b0, 1'b0, 4'd5},
      {1'b0, 8'd1, 1'b0, 1'b0, 4'd5},
      {1'b0, 8'd1, 1'b0, 1'b1, 4'd5},
      {1'b0, 8'd2, 1'b0, 1'b1, 4'd2}
   };

   task automatic check(input string req, input logic exp_t, input logic exp_c);
      checks++;
      if (en_true !== exp_t || en_comp !== exp_c) begin
         errors++;
         $display("FAIL %s: en_true=%0b en_comp=%0b expected %0b %0b",
                  req, en_true, en_comp, exp_t, exp_c);
      end
   endtask

   // R4 is checked after every edge.
   task automatic cyc(input logic p, input logic [7:0] d, input logic r);
      @(negedge clk);
      pwm_in      = p;
      dead_cycles = d;
      rst         = r;
      @(posedge clk);
      #1;
      checks++;
      if (en_true === 1'b1 && en_comp === 1'b1) begin
         errors++;
         $display("FAIL R4: en_true=%0b en_comp=%0b expected not both 1",
                  en_true, en_comp);
      end
   endtask

   initial begin
      logic [15:0] lfsr;
      int          lag;

      // R7 reset holds both low
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 8'd3, 1'b1);
         check("R7", 1'b0, 1'b0);
      end

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][14], VEC[i][13:6], 1'b0);
         check($sformatf("R%0d", VEC[i][3:0]), VEC[i][5], VEC[i][4]);
      end

      // R1 exact lag for several dead times
      for (int n = 0; n < 3; n++) begin
         logic [7:0] d;
         d = (n == 0) ? 8'd2 : (n == 1) ? 8'd5 : 8'd9;
         for (int i = 0; i < 12; i++) cyc(1'b0, d, 1'b0);
         lag = 0;
         cyc(1'b1, d, 1'b0);
         while (en_true !== 1'b1 && lag < 40) begin
            cyc(1'b1, d, 1'b0);
            lag++;
         end
         checks++;
         if (lag != int'(d)) begin
            errors++;
            $display("FAIL R1: lag=%0d expected %0d", lag, d);
         end
      end

      // R8 largest dead time and saturation
      for (int i = 0; i < 4; i++) cyc(1'b0, 8'd255, 1'b0);
      cyc(1'b1, 8'd255, 1'b0);
      check("R8", 1'b0, 1'b0);
      for (int j = 1; j < 255; j++) cyc(1'b1, 8'd255, 1'b0);
      check("R8", 1'b0, 1'b0);
      cyc(1'b1, 8'd255, 1'b0);
      check("R8", 1'b1, 1'b0);
      for (int j = 0; j < 300; j++) cyc(1'b1, 8'd255, 1'b0);
      check("R8", 1'b1, 1'b0);

      // R7 reset while en_true is high, then release with input unchanged
      cyc(1'b1, 8'd4, 1'b1);
      check("R7", 1'b0, 1'b0);
      cyc(1'b1, 8'd4, 1'b0);
      check("R7", 1'b1, 1'b0);
      // R7 input changes during reset: history follows it
      cyc(1'b0, 8'd4, 1'b1);
      check("R7", 1'b0, 1'b0);
      cyc(1'b0, 8'd4, 1'b0);
      check("R7", 1'b0, 1'b1);

      // R4 pseudo-random toggling
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0] ^ lfsr[3], 8'd2, 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule